// File: doc/BRIEF.md
# System Clock Divider with Power-Save Override and Activity Switchback

This block turns a fast source clock into a system clock enable. A 2-bit divide code picks one of four ratios: /1, /2, /4 or /8. A power-save bit overrides the code and forces a much slower ratio, /256 by default. The output is a single-cycle enable pulse, `clk_en`, once per divided period. Downstream logic stays on the source clock and advances only on the cycles where `clk_en` is high.

Software sets the divide code, the power-save bit and a switchback enable through a one-cycle write strobe. It reads the three fields back on dedicated outputs. Peripherals report activity on a vector of event lines. These lines are synchronised to the source clock. While both switchback and power-save are set, any synchronised event clears power-save and puts the divide code back to /1. Software cannot enter power-save while switchback would fire at once.

A ratio change never cuts a divided period short. The new ratio is picked up only at the end of the period in progress.

Top module: `clkdiv_pwrsave`

## Requirements
- R1: With power-save clear, divide code 00, 01, 10 and 11 give a `clk_en` pulse every 1, 2, 4 and 8 source cycles respectively.
- R2: With power-save set, `clk_en` pulses once every 2^PS_SHIFT source cycles (256 by default), whatever the divide code.
- R3: A write that leaves power-save clear while it was set also forces the divide code to 00, whatever code was written, so the clock returns to /1.
- R4: With switchback disabled, activity events leave power-save unchanged.
- R5: With switchback and power-save both set, and no write in the same cycle, a synchronised activity event on any line clears power-save and sets the divide code to 00.
- R6: A write with both the power-save and switchback bits at 1 is refused for power-save while any synchronised activity is present: power-save reads back 0 afterwards. The same write with switchback at 0 does set power-save.
- R7: A new ratio takes effect only at the next `clk_en` pulse. The period in progress completes at its old length.
- R8: An activity event passes through SYNC_STAGES flip-flops. It clears power-save SYNC_STAGES+1 rising edges after it is first sampled, not earlier, and a one-cycle pulse is enough.
- R9: Reset clears power-save and switchback and sets the divide code to 00 (a /1 enable, high every cycle).
- R10: After a write, the readback outputs show the written divide code, power-save and switchback values, unless R3 or R6 alters them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source (high-frequency) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle control write strobe |
| wr_div | input | 2 | Divide code to write (00=/1, 01=/2, 10=/4, 11=/8) |
| wr_psave | input | 1 | Power-save bit to write |
| wr_swb | input | 1 | Switchback enable to write |
| activity | input | NACT | Asynchronous activity event lines, active high |
| clk_en | output | 1 | Divided clock enable, one source cycle wide |
| rd_div | output | 2 | Current divide code |
| rd_psave | output | 1 | Current power-save bit |
| rd_swb | output | 1 | Current switchback enable |

## Verification
A write reaches the readback outputs on the rising edge that samples the strobe. The bench therefore checks readback at the falling edge right after that edge. An activity event clears power-save SYNC_STAGES+1 edges after it is first sampled. With two stages, the bench checks that power-save is still set at the second falling edge after the event and clear at the third.

Ratio changes are checked by measuring the gap between `clk_en` pulses. The bench skips two pulses after a change before it measures. For R7 it times the period during which the write arrives, and expects the old length.

// File: rtl/clkdiv_pwrsave.sv
module clkdiv_pwrsave #(
  parameter int NACT        = 12,
  parameter int SYNC_STAGES = 2,
  parameter int PS_SHIFT    = 8
) (
  input  logic            clk_src,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_div,
  input  logic            wr_psave,
  input  logic            wr_swb,
  input  logic [NACT-1:0] activity,
  output logic            clk_en,
  output logic [1:0]      rd_div,
  output logic            rd_psave,
  output logic            rd_swb
);
  localparam int CW = (PS_SHIFT < 4) ? 4 : PS_SHIFT;

  logic [SYNC_STAGES-1:0][NACT-1:0] sync_q;
  logic          act_any;
  logic          ps_q, ps_d, swb_q, swb_d;
  logic [1:0]    div_q, div_d;
  logic [CW-1:0] cnt_q, lim_q, nxt_lim;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= activity;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign act_any = |sync_q[SYNC_STAGES-1];

  always_comb begin
    ps_d  = ps_q;
    swb_d = swb_q;
    div_d = div_q;
    if (wr_en) begin
      swb_d = wr_swb;
      ps_d  = wr_psave & ~(wr_swb & act_any);
      div_d = wr_div;
    end else if (swb_q & ps_q & act_any) begin
      ps_d = 1'b0;
    end
    if (ps_q & ~ps_d) div_d = 2'b00;
  end

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= 1'b0;
      swb_q <= 1'b0;
      div_q <= 2'b00;
    end else begin
      ps_q  <= ps_d;
      swb_q <= swb_d;
      div_q <= div_d;
    end
  end

  assign nxt_lim = ps_q ? {CW{1'b1}} : ((CW'(1) << div_q) - CW'(1));
  assign clk_en  = (cnt_q == lim_q);

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (clk_en) begin
      cnt_q <= '0;
      lim_q <= nxt_lim;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign rd_div   = div_q;
  assign rd_psave = ps_q;
  assign rd_swb   = swb_q;
endmodule

// File: rtl/clkdiv_pwrsave_chk.sv
module clkdiv_pwrsave_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_psave,
  input logic          wr_swb,
  input logic          act_any,
  input logic          clk_en,
  input logic          psave_q,
  input logic          swb_q,
  input logic [1:0]    div_q,
  input logic [CW-1:0] lim_q
);
  p_code_ratio_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !psave_q) |=> ($countones(lim_q + CW'(1)) == 1 && lim_q < CW'(8)));

  p_psave_ratio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && psave_q) |=> (&lim_q));

  p_sw_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (psave_q && wr_en && !wr_psave) |=> (!psave_q && div_q == 2'b00));

  p_no_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !swb_q && psave_q) |=> psave_q);

  p_switchback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && swb_q && psave_q && act_any) |=> (!psave_q && div_q == 2'b00));

  p_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_psave && wr_swb && act_any) |=> !psave_q);

  p_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(lim_q));

  p_reset_r9: assert property (@(posedge clk)
    !rst_n |=> (!psave_q && !swb_q && div_q == 2'b00));
endmodule

bind clkdiv_pwrsave clkdiv_pwrsave_chk #(.CW(CW)) u_chk (
  .clk     (clk_src),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_psave(wr_psave),
  .wr_swb  (wr_swb),
  .act_any (act_any),
  .clk_en  (clk_en),
  .psave_q (ps_q),
  .swb_q   (swb_q),
  .div_q   (div_q),
  .lim_q   (lim_q)
);

// File: tb/clkdiv_pwrsave_bench.sv
module clkdiv_pwrsave_bench;
  localparam int NACT = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_div = 2'b00;
  logic wr_psave = 1'b0;
  logic wr_swb = 1'b0;
  logic [NACT-1:0] activity = '0;
  logic clk_en;
  logic [1:0] rd_div;
  logic rd_psave, rd_swb;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clkdiv_pwrsave #(.NACT(NACT), .SYNC_STAGES(2), .PS_SHIFT(8)) u_clkdiv_pwrsave (
    .clk_src(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_div(wr_div),
    .wr_psave(wr_psave), .wr_swb(wr_swb), .activity(activity),
    .clk_en(clk_en), .rd_div(rd_div), .rd_psave(rd_psave), .rd_swb(rd_swb)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] d, logic p, logic s);
    @(negedge clk);
    wr_en = 1'b1; wr_div = d; wr_psave = p; wr_swb = s;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!clk_en);
  endtask

  task automatic period(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!clk_en);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R9 div", rd_div, 0);
    chk("R9 psave", rd_psave, 0);
    chk("R9 swb", rd_swb, 0);
    chk("R9 clk_en", clk_en, 1);
    period(n); chk("R9 period", n, 1);

    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 4; c++) begin
        wr(2'(c), 1'(p), 1'(c & 1));
        chk("R10 div", rd_div, c);
        chk("R10 psave", rd_psave, p);
        chk("R10 swb", rd_swb, c & 1);
        wait_pulse(); wait_pulse();
        period(n);
        if (p == 1) chk("R2 period", n, 256);
        else        chk("R1 period", n, 1 << c);
      end
    end

    wr(2'b10, 1'b0, 1'b0);
    chk("R3 div", rd_div, 0);
    chk("R3 psave", rd_psave, 0);
    wait_pulse(); wait_pulse();
    period(n); chk("R3 period", n, 1);

    wr(2'b00, 1'b1, 1'b0);
    wait_pulse(); wait_pulse();
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 10) begin wr_en = 1'b1; wr_div = 2'b01; wr_psave = 1'b0; wr_swb = 1'b0; end
      if (n == 11) wr_en = 1'b0;
    end while (!clk_en);
    chk("R7 old period", n, 256);
    period(n); chk("R7 new period", n, 1);

    wr(2'b01, 1'b1, 1'b0);
    activity[3] = 1'b1;
    repeat (6) @(negedge clk);
    chk("R4 psave", rd_psave, 1);
    activity[3] = 1'b0;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NACT; i++) begin
      wr(2'b11, 1'b1, 1'b1);
      activity[i] = 1'b1;
      @(negedge clk);
      activity[i] = 1'b0;
      @(negedge clk);
      chk("R8 psave early", rd_psave, 1);
      @(negedge clk);
      chk("R5 psave", rd_psave, 0);
      chk("R5 div", rd_div, 0);
    end
    wait_pulse();
    period(n); chk("R5 period", n, 1);

    activity[0] = 1'b1;
    repeat (3) @(negedge clk);
    wr(2'b10, 1'b1, 1'b1);
    chk("R6 refused", rd_psave, 0);
    chk("R6 div", rd_div, 2);
    wr(2'b10, 1'b1, 1'b0);
    chk("R6 accepted", rd_psave, 1);
    activity[0] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 held", rd_psave, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule